// File: doc/BRIEF.md
# Peripheral Data Transfer Channel

This block is one lightweight DMA channel. It sits between the holding register of a serial peripheral and system memory. Software loads a 32-bit memory pointer and a 16-bit transfer count. Each ready strobe from the peripheral then causes one single-beat memory access.

For a receive channel, the access is a write of the received word to the pointer address. For a transmit channel, the access is a read, and the word read is handed to the peripheral. After every access the pointer advances by the configured element size and the count drops by one. When the count reaches zero, a sticky end-of-transfer flag rises toward the peripheral's interrupt logic. A zero count leaves the channel idle.

The direction comes from a strap input, `chan_is_rx`, which is tied at integration. It is sampled when each access starts.

Top module: `pchan_dma`

## Requirements
- R1: After a synchronous reset, `ptr_q`, `cnt_q`, `eot`, `mem_req` and `per_tx_valid` are all zero.
- R2: A pointer or count write appears on `ptr_q` or `cnt_q` one cycle later. A count write of a nonzero value clears `eot` in the same cycle as the load.
- R3: When `per_req` is sampled high in idle with a nonzero count, the next cycle shows `mem_req`=1, `mem_addr`=`ptr_q`, and `mem_we` equal to `chan_is_rx`. For receive, `mem_wdata` is the `per_rx_data` sampled with the strobe.
- R4: On a transmit channel, the cycle after `mem_ack` shows `per_tx_valid`=1 for exactly one cycle, with `per_tx_data` equal to the `mem_rdata` sampled with `mem_ack`. On a receive channel, `per_tx_valid` stays 0.
- R5: While `mem_ack` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady. `mem_req` drops in the cycle after the acknowledge.
- R6: On completion the pointer grows by a step set by `size_sel`: code 0 gives 1, code 1 gives 2, codes 2 and 3 give 4. The sum wraps modulo 2^32. The count decrements by one.
- R7: `eot` rises in the cycle after the completion that takes the count from 1 to 0. It stays high through later idle cycles and through zero-count writes, until a nonzero count write clears it.
- R8: With a zero count, `per_req` strobes cause no memory request.
- R9: Strobes that arrive while an access is outstanding, including in the acknowledge cycle, are dropped. No extra access follows.
- R10: A count write in the same cycle as a completion wins over the decrement. The pointer still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_is_rx | input | 1 | Strap: 1 = receive channel (memory write), 0 = transmit channel (memory read) |
| size_sel | input | 2 | Element size code: 0 = byte, 1 = half-word, 2 or 3 = word |
| ptr_wr_en | input | 1 | Load the pointer |
| ptr_wr_data | input | 32 | Pointer load value |
| cnt_wr_en | input | 1 | Load the count |
| cnt_wr_data | input | 16 | Count load value |
| ptr_q | output | 32 | Current memory pointer |
| cnt_q | output | 16 | Remaining transfers |
| per_req | input | 1 | Peripheral ready strobe |
| per_rx_data | input | 32 | Received data from the peripheral |
| per_tx_valid | output | 1 | One-cycle pulse: `per_tx_data` is valid |
| per_tx_data | output | 32 | Data fetched for the transmitter |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| eot | output | 1 | Sticky end-of-transfer flag |

## Verification
The hardest case to reach from the ports is a count write that lands in the same cycle as a memory acknowledge (R10). A late strobe that lands in that same cycle is similarly hard (R9).

The bench owns the memory responder. It raises `mem_ack` after a random delay, so it can line up the count write and an extra strobe with the acknowledge cycle exactly. It does this in directed cases, including a write of zero, and at random inside the constrained-random loop.

Pointer wrap at the top of the address space is driven directly. Transfer sequences with random sizes and directions cover the rest.

// File: rtl/pchan_pkg.sv
package pchan_pkg;

  typedef enum logic [1:0] {
    XS_BYTE = 2'd0,
    XS_HALF = 2'd1,
    XS_WORD = 2'd2,
    XS_WIDE = 2'd3
  } xsize_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } chan_st_e;

  localparam int STEP_W = 3;

  // Byte increment applied to the pointer for each size code.
  function automatic logic [STEP_W-1:0] step_bytes(input logic [1:0] code);
    case (xsize_e'(code))
      XS_BYTE: step_bytes = 3'd1;
      XS_HALF: step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pchan_ptr.sv
module pchan_ptr #(
  parameter int AW = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_data,
  input  logic                      done,
  input  logic [pchan_pkg::STEP_W-1:0] step,
  output logic [AW-1:0]             ptr
);

  // A software load takes precedence over the post-access advance.
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (wr_en) begin
      ptr <= wr_data;
    end else if (done) begin
      ptr <= ptr + AW'(step);
    end
  end

endmodule

// File: rtl/pchan_cnt.sv
module pchan_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          done,
  output logic [CW-1:0] cnt,
  output logic          cnt_nz,
  output logic          eot
);

  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      eot <= 1'b0;
    end else if (wr_en) begin
      cnt <= wr_data;
      if (wr_data != '0) eot <= 1'b0;
    end else if (done && (cnt != '0)) begin
      cnt <= cnt - ONE;
      if (cnt == ONE) eot <= 1'b1;
    end
  end

  assign cnt_nz = (cnt != '0);

endmodule

// File: rtl/pchan_fsm.sv
module pchan_fsm #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         per_req,
  input  logic [DW-1:0]                per_rx_data,
  input  logic                         chan_is_rx,
  input  logic [1:0]                   size_sel,
  input  logic [AW-1:0]                cur_ptr,
  input  logic                         cnt_nz,
  input  logic                         mem_ack,
  input  logic [DW-1:0]                mem_rdata,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [AW-1:0]                mem_addr,
  output logic [DW-1:0]                mem_wdata,
  output logic                         per_tx_valid,
  output logic [DW-1:0]                per_tx_data,
  output logic                         done,
  output logic [pchan_pkg::STEP_W-1:0] step
);

  import pchan_pkg::*;

  chan_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      per_tx_valid <= 1'b0;
      per_tx_data  <= '0;
      step         <= '0;
    end else begin
      per_tx_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (per_req && cnt_nz) begin
            st        <= ST_BUSY;
            mem_req   <= 1'b1;
            mem_we    <= chan_is_rx;
            mem_addr  <= cur_ptr;
            mem_wdata <= chan_is_rx ? per_rx_data : '0;
            step      <= step_bytes(size_sel);
          end
        end
        default: begin
          if (mem_ack) begin
            st      <= ST_IDLE;
            mem_req <= 1'b0;
            if (!mem_we) begin
              per_tx_valid <= 1'b1;
              per_tx_data  <= mem_rdata;
            end
          end
        end
      endcase
    end
  end

  assign done = (st == ST_BUSY) && mem_ack;

endmodule

// File: rtl/pchan_dma.sv
module pchan_dma #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chan_is_rx,
  input  logic [1:0]    size_sel,
  input  logic          ptr_wr_en,
  input  logic [AW-1:0] ptr_wr_data,
  input  logic          cnt_wr_en,
  input  logic [CW-1:0] cnt_wr_data,
  output logic [AW-1:0] ptr_q,
  output logic [CW-1:0] cnt_q,
  input  logic          per_req,
  input  logic [DW-1:0] per_rx_data,
  output logic          per_tx_valid,
  output logic [DW-1:0] per_tx_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          eot
);

  logic                         done;
  logic                         cnt_nz;
  logic [pchan_pkg::STEP_W-1:0] step;

  pchan_fsm #(.AW(AW), .DW(DW)) fsm_i (
    .clk          (clk),
    .rst          (rst),
    .per_req      (per_req),
    .per_rx_data  (per_rx_data),
    .chan_is_rx   (chan_is_rx),
    .size_sel     (size_sel),
    .cur_ptr      (ptr_q),
    .cnt_nz       (cnt_nz),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .per_tx_valid (per_tx_valid),
    .per_tx_data  (per_tx_data),
    .done         (done),
    .step         (step)
  );

  pchan_ptr #(.AW(AW)) ptr_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ptr_wr_en),
    .wr_data (ptr_wr_data),
    .done    (done),
    .step    (step),
    .ptr     (ptr_q)
  );

  pchan_cnt #(.CW(CW)) cnt_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cnt_wr_en),
    .wr_data (cnt_wr_data),
    .done    (done),
    .cnt     (cnt_q),
    .cnt_nz  (cnt_nz),
    .eot     (eot)
  );

endmodule

// File: rtl/pchan_dma_chk.sv
module pchan_dma_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [CW-1:0] cnt_q,
  input logic          cnt_wr_en,
  input logic [CW-1:0] cnt_wr_data,
  input logic          eot,
  input logic          per_tx_valid
);

  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);

  a_r8_zero_count_idle: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !mem_req) |=> !mem_req);

  a_r4_tx_pulse: assert property (@(posedge clk) disable iff (rst)
    per_tx_valid |=> !per_tx_valid);

  a_r7_eot_source: assert property (@(posedge clk) disable iff (rst)
    $rose(eot) |-> $past(mem_req && mem_ack));

  a_r2_eot_clear: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr_en && cnt_wr_data != '0) |=> !eot);

  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !cnt_wr_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

bind pchan_dma pchan_dma_chk #(.AW(AW), .DW(DW), .CW(CW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .cnt_q        (cnt_q),
  .cnt_wr_en    (cnt_wr_en),
  .cnt_wr_data  (cnt_wr_data),
  .eot          (eot),
  .per_tx_valid (per_tx_valid)
);

// File: tb/pchan_dma_tb.sv
module pchan_dma_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chan_is_rx = 1'b1;
  logic [1:0]  size_sel = 2'd0;
  logic        ptr_wr_en = 1'b0;
  logic [31:0] ptr_wr_data = '0;
  logic        cnt_wr_en = 1'b0;
  logic [15:0] cnt_wr_data = '0;
  logic [31:0] ptr_q;
  logic [15:0] cnt_q;
  logic        per_req = 1'b0;
  logic [31:0] per_rx_data = '0;
  logic        per_tx_valid;
  logic [31:0] per_tx_data;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        eot;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_ptr = '0;
  logic [15:0] exp_cnt = '0;
  logic        exp_eot = 1'b0;

  always #5 clk = ~clk;

  pchan_dma dut_i (
    .clk (clk), .rst (rst), .chan_is_rx (chan_is_rx), .size_sel (size_sel),
    .ptr_wr_en (ptr_wr_en), .ptr_wr_data (ptr_wr_data),
    .cnt_wr_en (cnt_wr_en), .cnt_wr_data (cnt_wr_data),
    .ptr_q (ptr_q), .cnt_q (cnt_q),
    .per_req (per_req), .per_rx_data (per_rx_data),
    .per_tx_valid (per_tx_valid), .per_tx_data (per_tx_data),
    .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .mem_ack (mem_ack), .mem_rdata (mem_rdata), .eot (eot)
  );

  function automatic logic [31:0] exp_step(input logic [1:0] code);
    if (code == 2'd0) return 32'd1;
    if (code == 2'd1) return 32'd2;
    return 32'd4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] p, input logic [15:0] c);
    @(negedge clk);
    ptr_wr_en = 1'b1; ptr_wr_data = p;
    cnt_wr_en = 1'b1; cnt_wr_data = c;
    @(negedge clk);
    ptr_wr_en = 1'b0; cnt_wr_en = 1'b0;
    exp_ptr = p; exp_cnt = c;
    if (c != 16'd0) exp_eot = 1'b0;
    chk("R2 ptr load", ptr_q, exp_ptr);
    chk("R2 cnt load", {16'd0, cnt_q}, {16'd0, exp_cnt});
    chk("R2 eot after load", {31'd0, eot}, {31'd0, exp_eot});
  endtask

  task automatic xfer(input logic [31:0] rxd, input int dly, input bit extra,
                      input bit collide, input logic [15:0] cval);
    logic [31:0] rd;
    logic        rx;
    rx = chan_is_rx;
    @(negedge clk);
    per_req = 1'b1; per_rx_data = rxd;
    @(negedge clk);
    per_req = 1'b0; per_rx_data = $urandom;
    chk("R3 mem_req", {31'd0, mem_req}, 32'd1);
    chk("R3 mem_addr", mem_addr, exp_ptr);
    chk("R3 mem_we", {31'd0, mem_we}, {31'd0, rx});
    if (rx) chk("R3 mem_wdata", mem_wdata, rxd);
    for (int i = 0; i < dly; i++) begin
      if (extra) per_req = 1'b1;
      @(negedge clk);
      per_req = 1'b0;
      chk("R5 req held", {31'd0, mem_req}, 32'd1);
      chk("R5 addr held", mem_addr, exp_ptr);
      if (rx) chk("R5 wdata held", mem_wdata, rxd);
    end
    rd = $urandom;
    mem_ack = 1'b1; mem_rdata = rd;
    if (collide) begin cnt_wr_en = 1'b1; cnt_wr_data = cval; end
    if (extra) per_req = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0; cnt_wr_en = 1'b0; per_req = 1'b0; mem_rdata = $urandom;
    exp_ptr = exp_ptr + exp_step(size_sel);
    if (collide) begin
      exp_cnt = cval;
      if (cval != 16'd0) exp_eot = 1'b0;
    end else begin
      exp_cnt = exp_cnt - 16'd1;
      if (exp_cnt == 16'd0) exp_eot = 1'b1;
    end
    chk("R5 req dropped", {31'd0, mem_req}, 32'd0);
    chk("R6 ptr advance", ptr_q, exp_ptr);
    if (collide) chk("R10 count write wins", {16'd0, cnt_q}, {16'd0, exp_cnt});
    else         chk("R6 count decrement", {16'd0, cnt_q}, {16'd0, exp_cnt});
    chk("R7 eot", {31'd0, eot}, {31'd0, exp_eot});
    if (!rx) begin
      chk("R4 tx valid", {31'd0, per_tx_valid}, 32'd1);
      chk("R4 tx data", per_tx_data, rd);
    end else begin
      chk("R4 rx no tx valid", {31'd0, per_tx_valid}, 32'd0);
    end
    @(negedge clk);
    chk("R9 no extra access", {31'd0, mem_req}, 32'd0);
    chk("R4 tx pulse one cycle", {31'd0, per_tx_valid}, 32'd0);
  endtask

  task automatic idle_strobe(input string tag);
    @(negedge clk);
    per_req = 1'b1; per_rx_data = $urandom;
    @(negedge clk);
    per_req = 1'b0;
    chk(tag, {31'd0, mem_req}, 32'd0);
    @(negedge clk);
    chk(tag, {31'd0, mem_req}, 32'd0);
    chk("R7 eot kept", {31'd0, eot}, {31'd0, exp_eot});
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 ptr", ptr_q, 32'd0);
    chk("R1 cnt", {16'd0, cnt_q}, 32'd0);
    chk("R1 eot", {31'd0, eot}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 tx_valid", {31'd0, per_tx_valid}, 32'd0);

    // R8: zero count after reset
    idle_strobe("R8 zero count no access");

    // Directed receive, byte size, run to end of transfer
    chan_is_rx = 1'b1; size_sel = 2'd0;
    load(32'h0000_1000, 16'd3);
    xfer(32'hA5A5_0001, 0, 1'b0, 1'b0, 16'd0);
    xfer(32'hA5A5_0002, 2, 1'b1, 1'b0, 16'd0);
    xfer(32'hA5A5_0003, 1, 1'b0, 1'b0, 16'd0);
    idle_strobe("R8 done channel no access");

    // Zero-count write keeps eot; nonzero clears it
    @(negedge clk); cnt_wr_en = 1'b1; cnt_wr_data = 16'd0;
    @(negedge clk); cnt_wr_en = 1'b0;
    chk("R7 eot kept on zero write", {31'd0, eot}, 32'd1);

    // Directed transmit, half and word sizes, pointer wrap
    chan_is_rx = 1'b0; size_sel = 2'd1;
    load(32'h2000_0000, 16'd2);
    xfer(32'd0, 3, 1'b1, 1'b0, 16'd0);
    size_sel = 2'd3;
    xfer(32'd0, 0, 1'b0, 1'b0, 16'd0);
    size_sel = 2'd2;
    load(32'hFFFF_FFFE, 16'd2);
    xfer(32'd0, 1, 1'b0, 1'b0, 16'd0);

    // R10 collisions: write nonzero then zero during acknowledge
    chan_is_rx = 1'b1;
    load(32'h0000_4000, 16'd1);
    xfer(32'h1234_5678, 1, 1'b1, 1'b1, 16'd5);
    xfer(32'h8765_4321, 0, 1'b0, 1'b1, 16'd0);
    idle_strobe("R8 collided to zero no access");

    // Constrained random
    for (int it = 0; it < 60; it++) begin
      int n;
      chan_is_rx = $urandom_range(0, 1);
      size_sel = 2'($urandom_range(0, 3));
      n = $urandom_range(1, 5);
      load($urandom, 16'(n));
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 9) == 0) begin
          xfer($urandom, $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'b1,
               16'($urandom_range(0, 2)));
          break;
        end
        xfer($urandom, $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'b0, 16'd0);
      end
      if (exp_cnt == 16'd0) idle_strobe("R8 random zero count");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule